// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates eight interrupt request lines the way a classic programmable interrupt controller does. It keeps three 8-bit state vectors: pending requests, levels currently being serviced, and a mask. It also keeps a pointer to the lowest-priority level. Each cycle a combinational scan starts just above that pointer and picks the winning request. A second scan finds the top in-service level, which a non-specific end-of-interrupt command needs.

A host drives one-cycle request pulses, an acknowledge strobe for the current winner, and command strobes that retire in-service levels or move the priority pointer. Three mode inputs select automatic end-of-interrupt, special mask mode and special fully nested mode. The block raises a request line that stays high until it is acknowledged. It also exposes the winning pin and its valid flag, and provides read-back of the three state vectors.

Top module: `rprio_resolver`

## Requirements
- R1: After synchronous reset, the request, in-service and mask vectors are all zero, `irq` and `win_valid` are low, and the lowest-priority pointer is 7, so pin 0 has top priority.
- R2: A 1 on `req_set[p]` sets request bit p at the next edge. `win_pin` names the highest-priority pending, unmasked pin, and `win_valid` flags it.
- R3: `mask_load` writes `mask_data` into the mask vector. A pin whose mask bit is 1 never wins.
- R4: The scan stops without a winner at the first pin whose in-service bit is set. That level and every lower level are blocked, while higher levels can still win.
- R5: `irq` rises one cycle after `win_valid` is seen while `irq` is low, and it stays high until `ack`. It is low in the cycle after `ack`.
- R6: `ack` with a valid winner p sets in-service bit p when auto-EOI is off. It also clears request bit p unless `req_active[p]` is 1.
- R7: With `mode_auto_eoi` = 1, `ack` leaves the in-service vector unchanged. If the stored rotate bit is 1, the pointer becomes p. The stored rotate bit is `cmd_rotate` of the last command.
- R8: A command with `cmd_eoi`=1 and `cmd_specific`=0 clears the highest-priority set in-service bit. In special mask mode, the search skips in-service bits whose mask bit is 1.
- R9: A command with `cmd_eoi`=1 and `cmd_specific`=1 clears in-service bit `cmd_level`. If `cmd_rotate`=1, the pointer is loaded with `cmd_level`.
- R10: A command with `cmd_eoi`=0, `cmd_specific`=1 and `cmd_rotate`=1 loads the pointer with `cmd_level`. With `cmd_rotate`=0, the same command leaves priority unchanged.
- R11: With `mode_special_mask`=1, in-service bits do not block requests; only the mask decides.
- R12: With `mode_special_nested`=1, in-service bit 2 (the cascade input) does not block.
- R13: The priority scan runs from pointer+1 upward and wraps modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 8 | One-cycle request pulses, one per pin |
| req_active | input | 8 | Present level of each request source |
| mask_load | input | 1 | Write strobe for the mask vector |
| mask_data | input | 8 | New mask value, 1 masks |
| mode_auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| mode_special_mask | input | 1 | Special mask mode |
| mode_special_nested | input | 1 | Special fully nested mode |
| ack | input | 1 | Acknowledge the current winner |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command retires an in-service level |
| cmd_specific | input | 1 | Command uses `cmd_level` |
| cmd_rotate | input | 1 | Rotation enable carried by the command |
| cmd_level | input | 3 | Level field of the command |
| irq | output | 1 | Interrupt request line |
| win_valid | output | 1 | A winner exists |
| win_pin | output | 3 | Winning pin number |
| irr_out | output | 8 | Pending request vector |
| isr_out | output | 8 | In-service vector |
| imr_out | output | 8 | Mask vector |

## Verification
Assertions are checked on every cycle for several properties: a winner is never masked and never sits on a blocking in-service level; acknowledge sets or preserves the in-service bit according to the auto-EOI mode; a specific end-of-interrupt always clears its level; and the request line rises only for a valid winner, holds until acknowledge, and falls after it. Only the bench scenarios can show the actual priority order. This covers where the scan starts after each kind of rotation, which bit a non-specific end-of-interrupt picks (including the masked-bit skip), and how the two special modes lift blocking in a real nesting sequence.

// File: rtl/rprio_pkg.sv
package rprio_pkg;

    localparam int IRQ_LINES   = 8;
    localparam int LVL_W       = $clog2(IRQ_LINES);
    localparam int CASCADE_PIN = 2;

    typedef logic [IRQ_LINES-1:0] pinvec_t;
    typedef logic [LVL_W-1:0]     lvl_t;

    localparam lvl_t RESET_LOWPRIO = lvl_t'(IRQ_LINES - 1);

    typedef struct packed {
        logic valid;
        lvl_t pin;
    } pick_t;

    typedef struct packed {
        logic eoi;
        logic specific;
        logic rotate;
        lvl_t level;
    } cmd_t;

    function automatic pinvec_t pin_bit(lvl_t p);
        return pinvec_t'(1) << p;
    endfunction

endpackage

// File: rtl/rprio_scan.sv
module rprio_scan
    import rprio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t cand,
    input  pinvec_t stop,
    input  lvl_t    lowprio,
    output pick_t   pick
);

    always_comb begin
        logic done;
        lvl_t p;
        pick = '0;
        done = 1'b0;
        for (int i = 0; i < IRQ_LINES; i++) begin
            p = lowprio + lvl_t'(i + 1);
            if (!done) begin
                if (stop[p]) begin
                    done = 1'b1;
                end else if (cand[p]) begin
                    done       = 1'b1;
                    pick.valid = 1'b1;
                    pick.pin   = p;
                end
            end
        end
    end

    // R2 / R3: a reported winner is a live candidate
    a_r3_pick_is_candidate: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> cand[pick.pin]);

    // R4: a reported winner never sits on a blocking level
    a_r4_pick_not_blocked: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> !stop[pick.pin]);

endmodule

// File: rtl/rprio_raise.sv
module rprio_raise (
    input  logic clk,
    input  logic rst,
    input  logic win_valid,
    input  logic ack,
    output logic irq
);

    logic raised_q;

    always_ff @(posedge clk) begin
        if (rst)            raised_q <= 1'b0;
        else if (ack)       raised_q <= 1'b0;
        else if (win_valid) raised_q <= 1'b1;
    end

    assign irq = raised_q;

    a_r5_low_after_ack: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq);

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);

    a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(win_valid));

endmodule

// File: rtl/rprio_resolver.sv
module rprio_resolver
    import rprio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_LINES-1:0] req_set,
    input  logic [IRQ_LINES-1:0] req_active,
    input  logic                 mask_load,
    input  logic [IRQ_LINES-1:0] mask_data,
    input  logic                 mode_auto_eoi,
    input  logic                 mode_special_mask,
    input  logic                 mode_special_nested,
    input  logic                 ack,
    input  logic                 cmd_valid,
    input  logic                 cmd_eoi,
    input  logic                 cmd_specific,
    input  logic                 cmd_rotate,
    input  logic [LVL_W-1:0]     cmd_level,
    output logic                 irq,
    output logic                 win_valid,
    output logic [LVL_W-1:0]     win_pin,
    output logic [IRQ_LINES-1:0] irr_out,
    output logic [IRQ_LINES-1:0] isr_out,
    output logic [IRQ_LINES-1:0] imr_out
);

    pinvec_t irr_q, isr_q, imr_q;
    pinvec_t irr_n, isr_n, imr_n;
    lvl_t    low_q, low_n;
    logic    rot_q, rot_n;

    cmd_t    cmd;
    pick_t   win, top_isr;
    pinvec_t blockers, eoi_cand;

    assign cmd = {cmd_eoi, cmd_specific, cmd_rotate, cmd_level};

    // Blocking set: special mask lifts all, special nesting lifts the cascade level
    always_comb begin
        blockers = isr_q;
        if (mode_special_nested) blockers = blockers & ~pin_bit(lvl_t'(CASCADE_PIN));
        if (mode_special_mask)   blockers = '0;
    end

    assign eoi_cand = mode_special_mask ? (isr_q & ~imr_q) : isr_q;

    rprio_scan u_req_scan (
        .clk     (clk),
        .rst     (rst),
        .cand    (irr_q & ~imr_q),
        .stop    (blockers),
        .lowprio (low_q),
        .pick    (win)
    );

    rprio_scan u_isr_scan (
        .clk     (clk),
        .rst     (rst),
        .cand    (eoi_cand),
        .stop    ('0),
        .lowprio (low_q),
        .pick    (top_isr)
    );

    rprio_raise u_raise (
        .clk       (clk),
        .rst       (rst),
        .win_valid (win.valid),
        .ack       (ack),
        .irq       (irq)
    );

    always_comb begin
        irr_n = irr_q | req_set;
        isr_n = isr_q;
        imr_n = mask_load ? mask_data : imr_q;
        low_n = low_q;
        rot_n = rot_q;

        if (ack && win.valid) begin
            if (!req_active[win.pin] && !req_set[win.pin]) irr_n[win.pin] = 1'b0;
            if (mode_auto_eoi) begin
                if (rot_q) low_n = win.pin;
            end else begin
                isr_n[win.pin] = 1'b1;
            end
        end

        if (cmd_valid) begin
            rot_n = cmd.rotate;
            if (cmd.eoi) begin
                if (cmd.specific) begin
                    isr_n[cmd.level] = 1'b0;
                    if (cmd.rotate) low_n = cmd.level;
                end else if (top_isr.valid) begin
                    isr_n[top_isr.pin] = 1'b0;
                    if (cmd.rotate) low_n = top_isr.pin;
                end
            end else if (cmd.specific && cmd.rotate) begin
                low_n = cmd.level;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
            imr_q <= '0;
            low_q <= RESET_LOWPRIO;
            rot_q <= 1'b0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            imr_q <= imr_n;
            low_q <= low_n;
            rot_q <= rot_n;
        end
    end

    assign win_valid = win.valid;
    assign win_pin   = win.pin;
    assign irr_out   = irr_q;
    assign isr_out   = isr_q;
    assign imr_out   = imr_q;

    a_r3_masked_never_wins: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> !imr_q[win.pin]);

    a_r4_plain_nesting: assert property (@(posedge clk) disable iff (rst)
        (win.valid && !mode_special_mask && !mode_special_nested) |-> !isr_q[win.pin]);

    a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (rst)
        (ack && win.valid && !mode_auto_eoi && !cmd_valid) |=> isr_q[$past(win.pin)]);

    a_r7_auto_eoi_keeps_isr: assert property (@(posedge clk) disable iff (rst)
        (ack && win.valid && mode_auto_eoi && !cmd_valid) |=> isr_q == $past(isr_q));

    a_r9_specific_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_eoi && cmd_specific) |=> !isr_q[$past(cmd_level)]);

endmodule

// File: tb/rprio_resolver_tb.sv
`timescale 1ns/1ps
module rprio_resolver_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_set = '0, req_active = '0, mask_data = '0;
    logic       mask_load = 0, mode_auto_eoi = 0, mode_special_mask = 0, mode_special_nested = 0;
    logic       ack = 0, cmd_valid = 0, cmd_eoi = 0, cmd_specific = 0, cmd_rotate = 0;
    logic [2:0] cmd_level = '0;
    logic       irq, win_valid;
    logic [2:0] win_pin;
    logic [7:0] irr_out, isr_out, imr_out;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    rprio_resolver u_dut (
        .clk(clk), .rst(rst), .req_set(req_set), .req_active(req_active),
        .mask_load(mask_load), .mask_data(mask_data),
        .mode_auto_eoi(mode_auto_eoi), .mode_special_mask(mode_special_mask),
        .mode_special_nested(mode_special_nested), .ack(ack),
        .cmd_valid(cmd_valid), .cmd_eoi(cmd_eoi), .cmd_specific(cmd_specific),
        .cmd_rotate(cmd_rotate), .cmd_level(cmd_level),
        .irq(irq), .win_valid(win_valid), .win_pin(win_pin),
        .irr_out(irr_out), .isr_out(isr_out), .imr_out(imr_out)
    );

    // {req[19:12], mask[11:4], valid[3], pin[2:0]} -- R2, R3, R13 at reset order
    localparam logic [19:0] VEC [8] = '{
        {8'h01, 8'h00, 1'b1, 3'd0},
        {8'h80, 8'h00, 1'b1, 3'd7},
        {8'h28, 8'h00, 1'b1, 3'd3},
        {8'hFF, 8'h0F, 1'b1, 3'd4},
        {8'hFF, 8'hFF, 1'b0, 3'd0},
        {8'h60, 8'h20, 1'b1, 3'd6},
        {8'h81, 8'h00, 1'b1, 3'd0},
        {8'h84, 8'h04, 1'b1, 3'd7}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] v);
        req_set = v; tick(); req_set = '0;
    endtask

    task automatic load_mask(input logic [7:0] m);
        mask_load = 1'b1; mask_data = m; tick(); mask_load = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic send_cmd(input logic e, input logic s, input logic r, input logic [2:0] l);
        cmd_valid = 1'b1; cmd_eoi = e; cmd_specific = s; cmd_rotate = r; cmd_level = l;
        tick();
        cmd_valid = 1'b0; cmd_eoi = 0; cmd_specific = 0; cmd_rotate = 0; cmd_level = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        check("R1 irr", irr_out, 0);
        check("R1 isr", isr_out, 0);
        check("R1 imr", imr_out, 0);
        check("R1 irq", irq, 0);
        check("R1 win_valid", win_valid, 0);

        // R2 / R3 / R13 table walk
        for (int k = 0; k < 8; k++) begin
            do_reset();
            load_mask(VEC[k][11:4]);
            pulse_req(VEC[k][19:12]);
            check("R2 R3 vector valid", win_valid, VEC[k][3]);
            if (VEC[k][3]) check("R2 R13 vector pin", win_pin, VEC[k][2:0]);
        end

        // R5 / R6 request line and acknowledge
        do_reset();
        pulse_req(8'h08);
        check("R5 irq not yet", irq, 0);
        tick();
        check("R5 irq up", irq, 1);
        tick(); tick();
        check("R5 irq held", irq, 1);
        do_ack();
        check("R5 irq down after ack", irq, 0);
        check("R6 isr set", isr_out, 8'h08);
        check("R6 irr cleared", irr_out, 8'h00);
        tick();
        check("R5 irq stays low", irq, 0);

        // R6 source still active, R4 nesting, R8 non-specific EOI
        do_reset();
        req_active = 8'h20;
        pulse_req(8'h20);
        tick();
        do_ack();
        check("R6 irr kept while active", irr_out, 8'h20);
        check("R6 isr bit5", isr_out, 8'h20);
        check("R4 self level blocked", win_valid, 0);
        pulse_req(8'h04);
        check("R4 higher passes valid", win_valid, 1);
        check("R4 higher passes pin", win_pin, 2);
        do_ack();
        check("R6 nested isr", isr_out, 8'h24);
        send_cmd(1, 0, 0, 0);
        check("R8 clears top level", isr_out, 8'h20);
        send_cmd(1, 0, 0, 0);
        check("R8 clears next", isr_out, 8'h00);
        check("R8 pending pin5 wins", win_pin, 5);
        req_active = '0;

        // R11 special mask, R8 skip of masked in-service bit
        do_reset();
        pulse_req(8'h02);
        do_ack();
        pulse_req(8'h10);
        check("R4 lower blocked", win_valid, 0);
        mode_special_mask = 1'b1;
        tick();
        check("R11 valid", win_valid, 1);
        check("R11 pin", win_pin, 4);
        do_ack();
        check("R11 isr", isr_out, 8'h12);
        load_mask(8'h02);
        send_cmd(1, 0, 0, 0);
        check("R8 skips masked level", isr_out, 8'h02);
        mode_special_mask = 1'b0;

        // R12 special fully nested
        do_reset();
        pulse_req(8'h04);
        do_ack();
        pulse_req(8'h04);
        check("R12 blocked when off", win_valid, 0);
        mode_special_nested = 1'b1;
        tick();
        check("R12 cascade passes valid", win_valid, 1);
        check("R12 cascade passes pin", win_pin, 2);
        mode_special_nested = 1'b0;

        // R9 specific EOI with rotation, R13 order after move
        send_cmd(1, 1, 1, 3'd2);
        check("R9 isr cleared", isr_out, 8'h00);
        pulse_req(8'h02);
        check("R9 R13 rotated winner", win_pin, 1);

        // R10 set priority
        do_reset();
        pulse_req(8'h41);
        check("R10 before", win_pin, 0);
        send_cmd(0, 1, 1, 3'd5);
        check("R10 pointer moved", win_pin, 6);
        send_cmd(0, 1, 0, 3'd0);
        check("R10 no rotate no effect", win_pin, 6);

        // R7 auto EOI with rotation
        do_reset();
        mode_auto_eoi = 1'b1;
        send_cmd(0, 0, 1, 3'd0);
        pulse_req(8'h09);
        check("R7 first winner", win_pin, 0);
        do_ack();
        check("R7 isr untouched", isr_out, 8'h00);
        check("R7 next winner", win_pin, 3);
        pulse_req(8'h01);
        check("R7 acked pin now lowest", win_pin, 3);
        mode_auto_eoi = 1'b0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule